// File: doc/BRIEF.md
# Power-Control Register Slave on a Two-Wire Serial Bus

This block lets a host program a small bank of power-control settings over an I2C-compatible two-wire bus. The host writes output-enable bits, sixteen-step voltage codes and discharge options, and reads them back. A fast system clock oversamples the serial clock and data lines. The block finds start and stop conditions, answers only its fixed 7-bit address, and pulls the open-drain data line low to acknowledge and to send read bits.

Written bytes do not reach the register bank as they arrive. They collect in a small staging buffer, tagged with their register index. The whole group lands in one system clock after the stop condition. The outputs that drive the regulators therefore never show a half-finished update. A read uses the pointer left by an earlier write, and ends when the host answers a byte with no acknowledge and then sends a stop.

The bus pins are plain level signals: the serial clock in, the resolved data level in, and a drive-low enable out. The block has no stream-style data handshake and does not stretch the clock. The host paces every transfer, and the register outputs are plain levels.

Top module: `pmic_i2c_regs`

## Requirements
- R1: After the active-low asynchronous reset, registers 0..7 hold 00, 04, 00, 0A, 0C, 06, 0F, 00 (hex; register k sits on regs_o[8k+7:8k]) and the data line is released (sda_oe_o = 0).
- R2: An address byte of 1001111 (MSB first), followed by the direction bit as LSB (0 = write, 1 = read), is acknowledged by holding the data line low during the ninth clock. Drive changes only while the serial clock is low.
- R3: For an address byte that does not match, the line is never driven and later bytes are ignored until the next start. Registers stay unchanged.
- R4: In a write, the first byte after the address sets the register pointer (its low 3 bits) and is acknowledged. Each acknowledged data byte goes to the pointed register, and the pointer then steps up by one, wrapping from 7 to 0.
- R5: Written bytes leave regs_o unchanged until the stop condition. At stop, all staged bytes are applied in arrival order within a few system clocks, and the block returns to standby.
- R6: At most 8 data bytes are staged per write. Any further data byte is answered with no acknowledge and discarded, while the first 8 are still applied at stop.
- R7: A read address sends regs[pointer] MSB first and steps the pointer after each byte. A host acknowledge fetches the next byte. A host no-acknowledge releases the line and leaves the block waiting for stop.
- R8: A write made of the pointer byte only changes no register but sets the pointer for a following read. A stop after a read returns the block to standby, ready for a new start.
- R9: A second start with no stop after the first abandons the open transaction. Staged bytes are dropped, nothing is acknowledged, and the line stays released until a stop is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Resolved data line level from the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| regs_o | output | 64 | Register bank, register k on bits 8k+7:8k |

## Verification
The assertions take the bus to be well formed. Data moves only while the serial clock is low, except for deliberate start and stop conditions. Each clock phase lasts long enough that every synchronized edge is seen, and a stop follows every transaction the block took part in. The bench master holds each clock phase for 20 system clocks and changes data only several clocks after the clock falls. It sends a stop only once the block has released the line, after a host no-acknowledge or after an acknowledged write byte. Start and stop edges therefore arise only where the bench intends them.

// File: rtl/pmic_i2c_pkg.sv
package pmic_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } eng_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_PTR, PH_DATA
  } rx_phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // [0],[1] synchronizer, [2] previous synchronized value
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign sda_lvl_o  = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import pmic_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001111,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             full_i,
  input  logic [7:0]       rd_byte_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             sda_oe_o,
  output logic             push_v_o,
  output logic [PTR_W-1:0] push_addr_o,
  output logic [7:0]       push_data_o,
  output logic             commit_o,
  output logic             clear_o
);
  eng_state_e st;
  rx_phase_e  ph;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic       rw, wr_open, mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_ADDR; bitcnt <= '0; sh <= '0;
      ptr_o <= '0; rw <= 1'b0; wr_open <= 1'b0; mack <= 1'b0;
      sda_oe_o <= 1'b0; push_v_o <= 1'b0; push_addr_o <= '0;
      push_data_o <= '0; commit_o <= 1'b0; clear_o <= 1'b0;
    end else begin
      push_v_o <= 1'b0;
      commit_o <= 1'b0;
      clear_o  <= 1'b0;
      if (stop_i) begin
        st <= ST_IDLE;
        sda_oe_o <= 1'b0;
        commit_o <= wr_open;
        wr_open  <= 1'b0;
      end else if (start_i) begin
        sda_oe_o <= 1'b0;
        clear_o  <= 1'b0 | 1'b1;
        wr_open  <= 1'b0;
        bitcnt   <= '0;
        if (st == ST_IDLE) begin
          st <= ST_RX;
          ph <= PH_ADDR;
        end else begin
          st <= ST_HOLD;  // start inside an open transaction: abandon it
        end
      end else begin
        case (st)
          ST_RX: begin
            if (rise_i && bitcnt < 4'd8) begin
              sh <= {sh[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (fall_i && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (ph)
                PH_ADDR: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    rw <= sh[0];
                    wr_open <= ~sh[0];
                    sda_oe_o <= 1'b1;
                    st <= ST_RX_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_PTR: begin
                  ptr_o <= sh[PTR_W-1:0];
                  sda_oe_o <= 1'b1;
                  st <= ST_RX_ACK;
                end
                default: begin
                  if (!full_i) begin
                    push_v_o <= 1'b1;
                    push_addr_o <= ptr_o;
                    push_data_o <= sh;
                    ptr_o <= ptr_o + PTR_W'(1);
                    sda_oe_o <= 1'b1;
                  end
                  st <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (fall_i) begin
              if (rw) begin
                sh <= rd_byte_i;
                ptr_o <= ptr_o + PTR_W'(1);
                sda_oe_o <= ~rd_byte_i[7];
                bitcnt <= '0;
                st <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                st <= ST_RX;
                ph <= (ph == PH_ADDR) ? PH_PTR : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (rise_i) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (fall_i) begin
              if (bitcnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                st <= ST_TX_ACK;
              end else begin
                sh <= {sh[6:0], 1'b0};
                sda_oe_o <= ~sh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (rise_i) begin
              mack <= ~sda_i;
            end else if (fall_i) begin
              if (mack) begin
                sh <= rd_byte_i;
                ptr_o <= ptr_o + PTR_W'(1);
                sda_oe_o <= ~rd_byte_i[7];
                bitcnt <= '0;
                st <= ST_TX;
              end else begin
                st <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the line is only ever taken low just after the serial clock fell
  assert_drive_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(fall_i));

  // R3: in standby the line is left alone
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe_o);

  // R5: a commit only ever follows a detected stop
  assert_commit_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(stop_i));

  // R9: a start inside an open transaction leaves the line released
  assert_restart_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && st != ST_IDLE) |=> !sda_oe_o);
endmodule

// File: rtl/stage_commit_bank.sv
module stage_commit_bank #(
  parameter int NREGS = 8,
  parameter int DEPTH = 8,
  parameter logic [NREGS*8-1:0] REG_INIT = '0,
  localparam int PTR_W = $clog2(NREGS),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_v_i,
  input  logic [PTR_W-1:0]   push_addr_i,
  input  logic [7:0]         push_data_i,
  input  logic               commit_i,
  input  logic               clear_i,
  input  logic [PTR_W-1:0]   rd_addr_i,
  output logic               full_o,
  output logic [7:0]         rd_byte_o,
  output logic [NREGS*8-1:0] regs_o
);
  logic [PTR_W-1:0] stg_addr [DEPTH];
  logic [7:0]       stg_data [DEPTH];
  logic [CNT_W-1:0] count;
  logic [7:0]       regs [NREGS];

  assign full_o    = (count == CNT_W'(DEPTH));
  assign rd_byte_o = regs[rd_addr_i];

  for (genvar g = 0; g < NREGS; g++) begin : g_flat
    assign regs_o[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stg_addr[i] <= '0;
        stg_data[i] <= '0;
      end
    end else if (commit_i || clear_i) begin
      count <= '0;
    end else if (push_v_i && !full_o) begin
      stg_addr[count[CNT_W-1:0]] <= push_addr_i;
      stg_data[count[CNT_W-1:0]] <= push_data_i;
      count <= count + CNT_W'(1);
    end
  end

  // Arrival order: a later entry overrides an earlier one to the same register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREGS; k++) regs[k] <= REG_INIT[k*8 +: 8];
    end else if (commit_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i < int'(count)) regs[stg_addr[i]] <= stg_data[i];
      end
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_v_i |-> !full_o);

  // R5: register outputs move only on a commit
  assert_regs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(regs_o));
endmodule

// File: rtl/pmic_i2c_regs.sv
module pmic_i2c_regs #(
  parameter int NREGS = 8,
  parameter int STAGE_DEPTH = 8,
  parameter logic [6:0] DEV_ADDR = 7'b1001111,
  parameter logic [NREGS*8-1:0] REG_INIT = 64'h000F_060C_0A00_0400,
  localparam int PTR_W = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [NREGS*8-1:0] regs_o
);
  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic full, push_v, commit, clear;
  logic [PTR_W-1:0] ptr, push_addr;
  logic [7:0] push_data, rd_byte;

  i2c_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl_o(sda_lvl), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_slave_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_lvl), .rise_i(scl_rise),
    .fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det),
    .full_i(full), .rd_byte_i(rd_byte), .ptr_o(ptr), .sda_oe_o(sda_oe_o),
    .push_v_o(push_v), .push_addr_o(push_addr), .push_data_o(push_data),
    .commit_o(commit), .clear_o(clear)
  );

  stage_commit_bank #(.NREGS(NREGS), .DEPTH(STAGE_DEPTH), .REG_INIT(REG_INIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .push_v_i(push_v), .push_addr_i(push_addr),
    .push_data_i(push_data), .commit_i(commit), .clear_i(clear),
    .rd_addr_i(ptr), .full_o(full), .rd_byte_o(rd_byte), .regs_o(regs_o)
  );
endmodule

// File: tb/pmic_i2c_regs_bench.sv
module pmic_i2c_regs_bench;
  localparam int H = 20;
  localparam logic [63:0] DEF = 64'h000F_060C_0A00_0400;
  localparam logic [7:0] AW = 8'h9E, AR = 8'h9F;
  // {pointer, data}
  localparam logic [15:0] VEC [6] = '{16'h0381, 16'h06A5, 16'h0000,
                                      16'h07FF, 16'h015C, 16'h043C};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, done = 1'b0;
  logic sda_oe;
  logic [63:0] regs;
  logic sda_bus;
  logic [7:0] exp_r [8];
  int checks = 0, errors = 0;

  assign sda_bus = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  pmic_i2c_regs u_pmic_i2c_regs (.clk(clk), .rst_n(rst_n), .scl_i(scl),
    .sda_i(sda_bus), .sda_oe_o(sda_oe), .regs_o(regs));

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    for (int k = 0; k < 8; k++) chk(tag, regs[k*8 +: 8], exp_r[k]);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H); sda_m = 1'b0; tick(H);
    scl = 1'b0; tick(4);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(H); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(4);
    end
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H/2); ack = ~sda_bus;
    tick(H/2); scl = 1'b0; tick(4);
  endtask

  task automatic recv_byte(input logic ackm, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1'b1; tick(H/2); b[i] = sda_bus; tick(H/2);
      scl = 1'b0; tick(4);
    end
    sda_m = ~ackm; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(4);
    sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    i2c_start(); send_byte(AW, a); send_byte(p, a); i2c_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    for (int k = 0; k < 8; k++) exp_r[k] = DEF[k*8 +: 8];
    tick(5); rst_n = 1'b1; tick(5);
    chk_regs("R1 reset value");
    chk("R1 line released", {7'd0, sda_oe}, 8'h00);

    // table walk: single-byte write, then pointer write and read back
    for (int v = 0; v < 6; v++) begin
      logic [7:0] p, dv;
      p = VEC[v][15:8]; dv = VEC[v][7:0];
      i2c_start();
      send_byte(AW, a); chk("R2 address ack", {7'd0, a}, 8'h01);
      send_byte(p, a);  chk("R4 pointer ack", {7'd0, a}, 8'h01);
      send_byte(dv, a); chk("R4 data ack", {7'd0, a}, 8'h01);
      i2c_stop(); tick(10);
      exp_r[p[2:0]] = dv;
      chk_regs("R5 after stop");
      set_ptr(p);
      i2c_start(); send_byte(AR, a); recv_byte(1'b0, d); i2c_stop();
      chk("R7 read back", d, dv);
    end

    // R5: nothing visible before stop; pointer increments
    i2c_start(); send_byte(AW, a); send_byte(8'h05, a);
    send_byte(8'h11, a); send_byte(8'h22, a);
    tick(10); chk_regs("R5 held before stop");
    i2c_stop(); tick(10);
    exp_r[5] = 8'h11; exp_r[6] = 8'h22;
    chk_regs("R5 applied at stop");

    // R4: pointer wraps 7 -> 0
    i2c_start(); send_byte(AW, a); send_byte(8'h07, a);
    send_byte(8'h77, a); send_byte(8'h70, a); i2c_stop(); tick(10);
    exp_r[7] = 8'h77; exp_r[0] = 8'h70;
    chk_regs("R4 pointer wrap");

    // R6: ninth data byte refused
    i2c_start(); send_byte(AW, a); send_byte(8'h00, a);
    for (int i = 0; i < 9; i++) begin
      send_byte(8'hC0 + 8'(i), a);
      chk(i < 8 ? "R6 staged ack" : "R6 overflow nack", {7'd0, a}, i < 8 ? 8'h01 : 8'h00);
      if (i < 8) exp_r[i] = 8'hC0 + 8'(i);
    end
    i2c_stop(); tick(10);
    chk_regs("R6 first eight applied");

    // R3: foreign address
    i2c_start(); send_byte(8'hA0, a); chk("R3 no ack on mismatch", {7'd0, a}, 8'h00);
    send_byte(8'h02, a); chk("R3 ignored byte", {7'd0, a}, 8'h00);
    send_byte(8'h99, a); chk("R3 ignored byte", {7'd0, a}, 8'h00);
    i2c_stop(); tick(10);
    chk_regs("R3 registers untouched");

    // R8 / R7: pointer-only write then burst read with ack, ack, nack
    set_ptr(8'h02); tick(10);
    chk_regs("R8 pointer-only write changes nothing");
    i2c_start(); send_byte(AR, a); chk("R2 read address ack", {7'd0, a}, 8'h01);
    recv_byte(1'b1, d); chk("R7 burst byte 0", d, exp_r[2]);
    recv_byte(1'b1, d); chk("R7 burst byte 1", d, exp_r[3]);
    recv_byte(1'b0, d); chk("R7 burst byte 2", d, exp_r[4]);
    tick(H); chk("R7 released after nack", {7'd0, sda_oe}, 8'h00);
    i2c_stop();

    // R9: second start without stop abandons the write
    i2c_start(); send_byte(AW, a); send_byte(8'h01, a); send_byte(8'h5A, a);
    chk("R9 data acked before restart", {7'd0, a}, 8'h01);
    i2c_start(); send_byte(AW, a); chk("R9 no ack after restart", {7'd0, a}, 8'h00);
    send_byte(8'h01, a); chk("R9 no ack after restart", {7'd0, a}, 8'h00);
    i2c_stop(); tick(10);
    chk_regs("R9 staged bytes dropped");

    // R8: standby after stop accepts a new transaction
    set_ptr(8'h01);
    i2c_start(); send_byte(AR, a); chk("R8 new transaction ack", {7'd0, a}, 8'h01);
    recv_byte(1'b0, d); i2c_stop();
    chk("R8 read after standby", d, exp_r[1]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule